// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge lets a host reach two internal register spaces, a PHY bank and a PLL bank, through a small window of directly mapped host registers. Each bank has up to 256 word registers. The host never touches them directly. It places an 8-bit bank address and a read/write flag in a control register. For a write it also loads a write-data register. It then flips the request bit that belongs to the wanted bank.

The bridge compares each request bit with the acknowledge bit beside it. A mismatch means that a transfer is outstanding. The bridge copies the address, the direction and the write data, and runs one transfer on a simple valid/ready internal bus to the selected bank. When the bank accepts the transfer, the bridge flips the matching acknowledge bit. For a read, it stores the returned word in a read-data register in the same cycle.

Software polls until the request and acknowledge bits are equal again. The control register can also be reached through set, clear and toggle alias offsets, so single fields can be changed without a read-modify-write.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the control register reads 0, the read-data register reads 0, and neither bank valid is asserted.
- R2: Only control bits 31, 26, 24, 15 and 7:0 are host-writable, and every other bit that is not an acknowledge bit reads 0. A host write at word offset 0 replaces these bits. Offset 1 ORs the data into them, offset 2 clears the bits that are 1 in the data, and offset 3 XORs the data into them.
- R3: Acknowledge bits 25 (PLL) and 27 (PHY) are owned by the bridge. Host writes to those positions at any alias offset leave them unchanged and start no transfer.
- R4: A transfer to the PLL bank is outstanding while bit 24 differs from bit 25. A transfer to the PHY bank is outstanding while bit 26 differs from bit 27. When a transfer starts, the bank address comes from bits 7:0, the direction from bit 31 (1 = read, 0 = write) and the write data from the write-data register at offset 4. These values are held stable on the internal bus, with the bank valid held high, until the bank asserts ready. Later host writes do not affect a transfer already running.
- R5: Each transfer flips the acknowledge bit of its own bank exactly once, at the clock edge where the bank valid and ready are both high.
- R6: At the completion edge of a read, the bank's read data is stored in the read-data register at offset 5. That register keeps its value until the next read completes.
- R7: At most one bank valid is asserted at any time. If both banks have a transfer outstanding while the bridge is idle, the PHY bank is served first. A request that arrives while a transfer is running waits until that transfer completes.
- R8: While control bit 15 is 0, the internal interface is held in reset. No bank valid is asserted, a running transfer is abandoned, and both acknowledge bits are forced to equal their request bits. As a result, clearing bit 15 and then setting it again starts no transfer.
- R9: Host reads at offsets 0 to 3 return the control register. Offset 4 returns the write-data register, offset 5 returns the read-data register, and offsets 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host word offset, used for both reads and writes |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` (combinational) |
| ibus_addr | output | 8 | Bank register address of the current transfer |
| ibus_we | output | 1 | 1 = write transfer, 0 = read transfer |
| ibus_wdata | output | 32 | Write data of the current transfer |
| phy_valid | output | 1 | PHY bank transfer valid |
| phy_ready | input | 1 | PHY bank accepts the transfer |
| phy_rdata | input | 32 | PHY bank read data, sampled when ready |
| pll_valid | output | 1 | PLL bank transfer valid |
| pll_ready | input | 1 | PLL bank accepts the transfer |
| pll_rdata | input | 32 | PLL bank read data, sampled when ready |

## Verification
The hardest situation to reach from the ports is a second request arriving while a transfer is running, with the control fields rewritten in between. The bench models slow banks that delay their ready by several cycles. It flips the PHY request, and while that transfer is still waiting it rewrites the address and write data and flips the PLL request. It then checks that each bank received its own address and data, in the order PHY first, then PLL. A single toggle-alias write that flips both request bits at once tests the priority between the banks. Full address sweeps of both banks, with the ready delay varied from transfer to transfer, cover both transfer directions.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
    localparam int DW     = 32;
    localparam int AW     = 8;
    localparam int HAW    = 3;
    localparam int NBANK  = 2;
    localparam int BANK_W = $clog2(NBANK);

    // control register bit positions
    localparam int RSTN_BIT = 15;
    localparam int PLL_REQ  = 24;
    localparam int PLL_ACK  = 25;
    localparam int PHY_REQ  = 26;
    localparam int PHY_ACK  = 27;
    localparam int RWB_BIT  = 31;

    localparam logic [DW-1:0] WMASK = (DW'(1) << RWB_BIT) | (DW'(1) << PHY_REQ) |
                                      (DW'(1) << PLL_REQ) | (DW'(1) << RSTN_BIT) |
                                      DW'((1 << AW) - 1);

    localparam logic [BANK_W-1:0] BANK_PLL = BANK_W'(0);
    localparam logic [BANK_W-1:0] BANK_PHY = BANK_W'(1);

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_TOG  = 2'd3
    } alias_op_e;

    localparam logic [HAW-1:0] OFS_WDATA = HAW'(4);
    localparam logic [HAW-1:0] OFS_RDATA = HAW'(5);

    typedef struct packed {
        logic              rwb;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     wdata;
        logic [BANK_W-1:0] bank;
    } xfer_t;

    function automatic logic [DW-1:0] apply_alias(alias_op_e op, logic [DW-1:0] cur,
                                                  logic [DW-1:0] wd);
        logic [DW-1:0] r;
        case (op)
            OP_LOAD: r = wd;
            OP_SET:  r = cur | wd;
            OP_CLR:  r = cur & ~wd;
            default: r = cur ^ wd;
        endcase
        return r & WMASK;
    endfunction

    // highest index wins: the PHY bank has priority
    function automatic logic [BANK_W-1:0] pick_bank(logic [NBANK-1:0] pend);
        logic [BANK_W-1:0] s;
        s = '0;
        for (int i = 0; i < NBANK; i++)
            if (pend[i]) s = BANK_W'(i);
        return s;
    endfunction
endpackage

// File: rtl/ibr_ctrl_reg.sv
module ibr_ctrl_reg
    import ibr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  alias_op_e        op,
    input  logic [DW-1:0]    wdata,
    input  logic [NBANK-1:0] ack_tog,
    output logic [DW-1:0]    ctrl_q
);
    logic [DW-1:0]    sw_q, sw_nxt;
    logic [NBANK-1:0] ack_q, req_nxt;

    always_comb begin
        sw_nxt  = wr_en ? apply_alias(op, sw_q, wdata) : sw_q;
        req_nxt = {sw_nxt[PHY_REQ], sw_nxt[PLL_REQ]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q  <= '0;
            ack_q <= '0;
        end else begin
            sw_q <= sw_nxt;
            if (!sw_nxt[RSTN_BIT])
                ack_q <= req_nxt;
            else
                ack_q <= ack_q ^ ack_tog;
        end
    end

    always_comb begin
        ctrl_q          = sw_q;
        ctrl_q[PHY_ACK] = ack_q[BANK_PHY];
        ctrl_q[PLL_ACK] = ack_q[BANK_PLL];
    end
endmodule

// File: rtl/ibr_engine.sv
module ibr_engine
    import ibr_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic [NBANK-1:0]          req,
    input  logic [NBANK-1:0]          ack,
    input  logic                      rwb,
    input  logic [AW-1:0]             addr,
    input  logic [DW-1:0]             wdata,
    input  logic [NBANK-1:0]          bank_ready,
    input  logic [NBANK-1:0][DW-1:0]  bank_rdata,
    output logic [NBANK-1:0]          bank_valid,
    output logic [AW-1:0]             ibus_addr,
    output logic                      ibus_we,
    output logic [DW-1:0]             ibus_wdata,
    output logic [NBANK-1:0]          ack_tog,
    output logic [DW-1:0]             rdata_q
);
    logic             busy;
    xfer_t            cur;
    logic [NBANK-1:0] pending;
    logic             done;

    assign pending    = req ^ ack;
    assign done       = busy && en && bank_ready[cur.bank];
    assign ack_tog    = done ? (NBANK'(1) << cur.bank) : '0;
    assign ibus_addr  = cur.addr;
    assign ibus_we    = ~cur.rwb;
    assign ibus_wdata = cur.wdata;

    for (genvar b = 0; b < NBANK; b++) begin : g_valid
        assign bank_valid[b] = busy && en && (cur.bank == BANK_W'(b));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cur     <= '0;
            rdata_q <= '0;
        end else if (!en) begin
            busy <= 1'b0;
        end else if (busy) begin
            if (done) begin
                busy <= 1'b0;
                if (cur.rwb)
                    rdata_q <= bank_rdata[cur.bank];
            end
        end else if (|pending) begin
            busy <= 1'b1;
            cur  <= '{rwb: rwb, addr: addr, wdata: wdata, bank: pick_bank(pending)};
        end
    end
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
    import ibr_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           host_we,
    input  logic [HAW-1:0] host_addr,
    input  logic [DW-1:0]  host_wdata,
    output logic [DW-1:0]  host_rdata,
    output logic [AW-1:0]  ibus_addr,
    output logic           ibus_we,
    output logic [DW-1:0]  ibus_wdata,
    output logic           phy_valid,
    input  logic           phy_ready,
    input  logic [DW-1:0]  phy_rdata,
    output logic           pll_valid,
    input  logic           pll_ready,
    input  logic [DW-1:0]  pll_rdata
);
    logic [DW-1:0]             ctrl_q, wdata_q, rdata_q;
    logic                      ctrl_wr;
    logic [NBANK-1:0]          ack_tog, bank_valid;
    logic [NBANK-1:0][DW-1:0]  bank_rdata;

    assign ctrl_wr = host_we && (host_addr[HAW-1] == 1'b0);

    ibr_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctrl_wr),
        .op      (alias_op_e'(host_addr[1:0])),
        .wdata   (host_wdata),
        .ack_tog (ack_tog),
        .ctrl_q  (ctrl_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            wdata_q <= '0;
        else if (host_we && host_addr == OFS_WDATA)
            wdata_q <= host_wdata;
    end

    assign bank_rdata[BANK_PHY] = phy_rdata;
    assign bank_rdata[BANK_PLL] = pll_rdata;

    ibr_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .en         (ctrl_q[RSTN_BIT]),
        .req        ({ctrl_q[PHY_REQ], ctrl_q[PLL_REQ]}),
        .ack        ({ctrl_q[PHY_ACK], ctrl_q[PLL_ACK]}),
        .rwb        (ctrl_q[RWB_BIT]),
        .addr       (ctrl_q[AW-1:0]),
        .wdata      (wdata_q),
        .bank_ready ({phy_ready, pll_ready}),
        .bank_rdata (bank_rdata),
        .bank_valid (bank_valid),
        .ibus_addr  (ibus_addr),
        .ibus_we    (ibus_we),
        .ibus_wdata (ibus_wdata),
        .ack_tog    (ack_tog),
        .rdata_q    (rdata_q)
    );

    assign phy_valid = bank_valid[BANK_PHY];
    assign pll_valid = bank_valid[BANK_PLL];

    always_comb begin
        if (host_addr[HAW-1] == 1'b0)   host_rdata = ctrl_q;
        else if (host_addr == OFS_WDATA) host_rdata = wdata_q;
        else if (host_addr == OFS_RDATA) host_rdata = rdata_q;
        else                             host_rdata = '0;
    end
endmodule

// File: rtl/ibr_chk.sv
module ibr_chk
    import ibr_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] ctrl_q,
    input logic [DW-1:0] rdata_q,
    input logic          phy_valid,
    input logic          phy_ready,
    input logic          pll_valid,
    input logic          pll_ready,
    input logic [AW-1:0] ibus_addr,
    input logic          ibus_we,
    input logic [DW-1:0] ibus_wdata
);
    // R7
    one_bank_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({phy_valid, pll_valid}));

    // R4
    phy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        phy_valid && !phy_ready |=> !ctrl_q[RSTN_BIT] ||
        (phy_valid && $stable(ibus_addr) && $stable(ibus_we) && $stable(ibus_wdata)));

    // R4
    pll_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pll_valid && !pll_ready |=> !ctrl_q[RSTN_BIT] ||
        (pll_valid && $stable(ibus_addr) && $stable(ibus_we) && $stable(ibus_wdata)));

    // R5
    phy_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[RSTN_BIT] && $past(ctrl_q[RSTN_BIT]) && (ctrl_q[PHY_ACK] != $past(ctrl_q[PHY_ACK]))
        |-> $past(phy_valid && phy_ready));

    // R5
    pll_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[RSTN_BIT] && $past(ctrl_q[RSTN_BIT]) && (ctrl_q[PLL_ACK] != $past(ctrl_q[PLL_ACK]))
        |-> $past(pll_valid && pll_ready));

    // R6
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rdata_q != $past(rdata_q)) |->
        $past(((phy_valid && phy_ready) || (pll_valid && pll_ready)) && !ibus_we));

    // R8
    off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[RSTN_BIT] |-> !phy_valid && !pll_valid);
endmodule

bind ind_reg_bridge ibr_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_q     (ctrl_q),
    .rdata_q    (rdata_q),
    .phy_valid  (phy_valid),
    .phy_ready  (phy_ready),
    .pll_valid  (pll_valid),
    .pll_ready  (pll_ready),
    .ibus_addr  (ibus_addr),
    .ibus_we    (ibus_we),
    .ibus_wdata (ibus_wdata)
);

// File: tb/ind_reg_bridge_bench.sv
module ind_reg_bridge_bench;
    localparam int O_CTRL = 0, O_SET = 1, O_CLR = 2, O_TOG = 3, O_WD = 4, O_RD = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata, ibus_wdata;
    logic [7:0]  ibus_addr;
    logic        ibus_we, phy_valid, pll_valid;
    logic [1:0]  rdy, vld;
    logic [31:0] mem [2][256];
    int          dly [2];
    int          cnt [2];
    int          acc [2];
    int          logb [16];
    int          logi = 0;
    int          errors = 0, checks = 0;

    always #5 clk = ~clk;

    assign vld = {phy_valid, pll_valid};
    for (genvar b = 0; b < 2; b++) begin : g_bank
        assign rdy[b] = vld[b] && (cnt[b] >= dly[b]);
    end

    ind_reg_bridge u_ind_reg_bridge (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ibus_addr(ibus_addr), .ibus_we(ibus_we), .ibus_wdata(ibus_wdata),
        .phy_valid(phy_valid), .phy_ready(rdy[1]), .phy_rdata(mem[1][ibus_addr]),
        .pll_valid(pll_valid), .pll_ready(rdy[0]), .pll_rdata(mem[0][ibus_addr])
    );

    always @(posedge clk) begin
        for (int b = 0; b < 2; b++) begin
            if (rst) begin
                cnt[b] <= 0;
                acc[b] <= 0;
            end else if (vld[b] && rdy[b]) begin
                cnt[b] <= 0;
                acc[b] <= acc[b] + 1;
                logb[logi % 16] <= b;
                logi <= logi + 1;
                if (ibus_we) mem[b][ibus_addr] <= ibus_wdata;
            end else if (vld[b]) begin
                cnt[b] <= cnt[b] + 1;
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwr(int a, logic [31:0] d);
        @(negedge clk);
        host_addr = 3'(a); host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hrd(int a, output logic [31:0] d);
        @(negedge clk);
        host_addr = 3'(a);
        #1 d = host_rdata;
    endtask

    task automatic wait_bank(int b, string req);
        logic [31:0] v;
        int rq = (b == 1) ? 26 : 24;
        for (int i = 0; i < 300; i++) begin
            hrd(O_CTRL, v);
            if (v[rq] == v[rq+1]) return;
        end
        chk(req, 32'hDEAD, 32'h0);
    endtask

    task automatic xfer(int b, bit rd, logic [7:0] a, logic [31:0] wd);
        hwr(O_CLR, 32'h8000_00FF);
        hwr(O_SET, {rd, 23'd0, a});
        if (!rd) hwr(O_WD, wd);
        hwr(O_TOG, (b == 1) ? 32'h0400_0000 : 32'h0100_0000);
        wait_bank(b, "R5 handshake");
    endtask

    function automatic logic [31:0] pat(int b, int a);
        return 32'h9E37_79B9 * 32'(a + 1 + b * 256);
    endfunction

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v, rsave;
        int a0, a1, nx0, nx1;
        dly[0] = 0; dly[1] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        hrd(O_CTRL, v); chk("R1 ctrl", v, 32'h0);
        hrd(O_RD, v);   chk("R1 rdata", v, 32'h0);
        chk("R1 valids", {30'd0, vld}, 32'h0);
        // R2 aliases with interface held off (acks follow reqs, R8)
        hwr(O_CTRL, 32'h8500_00FF); hrd(O_CTRL, v); chk("R2 load", v, 32'h8F00_00FF);
        hwr(O_CLR, 32'h0400_0001);  hrd(O_CTRL, v); chk("R2 clear", v, 32'h8300_00FE);
        hwr(O_TOG, 32'h8000_0003);  hrd(O_CTRL, v); chk("R2 toggle", v, 32'h0300_00FD);
        hwr(O_SET, 32'h0000_0002);  hrd(O_CTRL, v); chk("R2 set", v, 32'h0300_00FF);
        hwr(O_CTRL, 32'h7A7A_7A00); hrd(O_CTRL, v); chk("R2 unmapped bits", v, 32'h0);
        chk("R8 no access while off", 32'(acc[0] + acc[1]), 32'h0);
        // R9 offsets
        hwr(O_WD, 32'hCAFE_F00D);
        hrd(O_WD, v); chk("R9 wdata readback", v, 32'hCAFE_F00D);
        hrd(6, v); chk("R9 offset 6", v, 32'h0);
        hrd(7, v); chk("R9 offset 7", v, 32'h0);
        // R3 ack bits not host writable
        hwr(O_CTRL, 32'h0000_8000);
        hwr(O_TOG, 32'h0A00_0000);
        hwr(O_SET, 32'h0A00_0000);
        repeat (6) @(negedge clk);
        hrd(O_CTRL, v); chk("R3 ack untouched", v, 32'h0000_8000);
        chk("R3 no transfer", 32'(acc[0] + acc[1]), 32'h0);
        // R8 reset of interface discards a toggle
        hwr(O_CLR, 32'h0000_8000);
        hwr(O_TOG, 32'h0400_0000);
        hwr(O_SET, 32'h0000_8000);
        repeat (8) @(negedge clk);
        hrd(O_CTRL, v); chk("R8 ack forced", v, 32'h0C00_8000);
        chk("R8 no transfer", 32'(acc[0] + acc[1]), 32'h0);
        // R4 R5 R6 sweep of both banks
        nx0 = 0; nx1 = 0;
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 2; b++) begin
                dly[b] = a % 4;
                xfer(b, 1'b0, 8'(a), pat(b, a));
                chk("R4 bank write", mem[b][a], pat(b, a));
                if (b == 1) nx1++; else nx0++;
            end
        end
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 2; b++) begin
                dly[b] = (a + b) % 3;
                xfer(b, 1'b1, 8'(a), 32'h0);
                hrd(O_RD, v); chk("R6 read data", v, pat(b, a));
                if (b == 1) nx1++; else nx0++;
            end
        end
        chk("R5 pll count", 32'(acc[0]), 32'(nx0));
        chk("R5 phy count", 32'(acc[1]), 32'(nx1));
        // R6 rdata held across a write
        hrd(O_RD, rsave);
        xfer(0, 1'b0, 8'h40, 32'h1234_5678);
        hrd(O_RD, v); chk("R6 stable after write", v, rsave);
        // R7 priority: both requests in one toggle
        dly[0] = 3; dly[1] = 3;
        hwr(O_CLR, 32'h8000_00FF);
        hwr(O_SET, 32'h0000_0033);
        hwr(O_WD, 32'h5555_AAAA);
        a0 = logi;
        hwr(O_TOG, 32'h0500_0000);
        wait_bank(1, "R7 phy");
        wait_bank(0, "R7 pll");
        chk("R7 first is phy", 32'(logb[a0 % 16]), 32'd1);
        chk("R7 second is pll", 32'(logb[(a0 + 1) % 16]), 32'd0);
        chk("R7 pll data", mem[0][8'h33], 32'h5555_AAAA);
        // R7 R4 request held during busy, snapshot kept
        dly[1] = 8;
        hwr(O_CLR, 32'h8000_00FF);
        hwr(O_SET, 32'h0000_0011);
        hwr(O_WD, 32'hAAAA_0001);
        a1 = logi;
        hwr(O_TOG, 32'h0400_0000);
        hwr(O_CLR, 32'h0000_00FF);
        hwr(O_SET, 32'h0000_0022);
        hwr(O_WD, 32'hBBBB_0002);
        hwr(O_TOG, 32'h0100_0000);
        wait_bank(1, "R7 phy busy");
        wait_bank(0, "R7 pll held");
        chk("R4 phy snapshot", mem[1][8'h11], 32'hAAAA_0001);
        chk("R7 pll after phy", mem[0][8'h22], 32'hBBBB_0002);
        chk("R7 held order", 32'(logb[a1 % 16]), 32'd1);
        chk("R7 one each", 32'(logi - a1), 32'd2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule